// File: doc/BRIEF.md
# Unaligned Burst Write Packer

This block sits in front of the user port of a DDR2-style memory controller. The port is 64 bits wide and takes fixed bursts of four 32-bit words, carried as two 64-bit beats. A client asks for a run of 32-bit words. The run may begin at any word address and has a word count. The packer takes the words one at a time over a valid/ready handshake and places each one in the lower or upper half of a beat. It blocks the lanes that fall outside the run with a per-byte write mask. It also steps the burst command address, so the memory ends up holding exactly the requested words and nothing else.

The controller does not look at the two low address bits on writes. The packer therefore handles any misalignment itself. Leading lanes before the first word are masked, and the burst that holds the last word is padded to its full four slots with masked lanes.

Control is a three-state machine. IDLE waits for an accepted start. FILL builds one beat, one lane per cycle: a padding lane costs one cycle, and a data lane waits for an input word. SEND presents the finished beat and holds it until the controller accepts it. The transitions are named as follows:
- start-with-words: IDLE to FILL.
- beat-built: FILL to SEND, once the upper lane is placed.
- next-beat: SEND to FILL on acceptance, while words or the second beat of a burst remain.
- run-finished: SEND to IDLE on acceptance of the second beat of a burst when no words are left.

Top module: `wr_burst_packer`

## Requirements
- R1: After reset the block is idle: busy_o, word_ready_o, beat_valid_o, cmd_valid_o and done_o are all low.
- R2: Every burst is exactly two accepted beats. cmd_valid_o is high on the first beat of each burst, together with beat_valid_o, and low on the second beat.
- R3: The first burst command carries the start address unchanged. Each later command of the same run carries an address 4 higher, wrapping modulo 2^ADDR_W.
- R4: The word at position p of a run (p = 0 first) goes into slot s = (start mod 4) + p, counted across the run's bursts. Slot s is in the first beat of its burst when (s mod 4) < 2, otherwise in the second beat. It is in bits 31:0 when s is even and in bits 63:32 when s is odd.
- R5: A set mask bit blocks its byte. Mask bits 3:0 cover bits 31:0 and mask bits 7:4 cover bits 63:32. Each lane's nibble is either 0x0 (word written) or 0xF (blocked). Blocked lanes carry zero data, and every lane that holds no run word is blocked, including the padding up to the end of the last burst.
- R6: While beat_valid_o is high and mc_ready_i is low, the beat data, mask, command strobe and command address stay unchanged. No beat is lost or repeated.
- R7: done_o is high for exactly one cycle, in the cycle right after the final beat of the run is accepted, and busy_o is low at that point.
- R8: A start with a word count of zero produces no beats and raises done_o in the next cycle.
- R9: A start pulse while busy_o is high is ignored, and the run in progress completes unchanged.
- R10: word_ready_o is high only while a lane is being filled. Exactly word-count input words are consumed per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| start_addr_i | input | ADDR_W | Word address of the first word of the run |
| word_cnt_i | input | CNT_W | Number of words in the run |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| word_valid_i | input | 1 | Input word present |
| word_data_i | input | 32 | Input word |
| word_ready_o | output | 1 | Packer takes the input word this cycle |
| cmd_valid_o | output | 1 | Address strobe, first beat of a burst |
| cmd_addr_o | output | ADDR_W | Burst command address |
| beat_valid_o | output | 1 | Data strobe |
| beat_data_o | output | 64 | Beat data, two 32-bit lanes |
| beat_mask_o | output | 8 | Per-byte write mask, set = blocked |
| mc_ready_i | input | 1 | Controller accepts the current beat |

## Verification
The bench acts as the controller and applies accepted beats to a memory image that holds a background pattern. It then compares the whole image against the intended result, for every start offset from 0 to 3 and for lengths that end on every lane position. A packer that misplaced a lane, left a padding lane unmasked, or dropped the trailing pad beat would corrupt neighbouring words or leave a burst with one beat. Stalls on both handshakes catch a beat that changes or repeats while the controller holds off. A start address near the top of the address range catches a command address that does not wrap. A start pulse during a run catches a run that restarts, and a zero-length request catches a run that hangs or emits beats.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
    localparam int WORD_W      = 32;
    localparam int LANES       = 2;
    localparam int BEAT_W      = WORD_W * LANES;
    localparam int LANE_BYTES  = WORD_W / 8;
    localparam int MASK_W      = BEAT_W / 8;
    localparam int BURST_BEATS = 2;
    localparam int BURST_WORDS = LANES * BURST_BEATS;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2
    } pkr_state_e;
endpackage

// File: rtl/pkr_lane_step.sv
module pkr_lane_step #(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       lead_i,
    input  logic [CNT_W-1:0] left_i,
    input  logic             word_valid_i,
    output logic             want_word_o,
    output logic             advance_o,
    output logic             is_word_o,
    output logic [1:0]       lead_nxt_o,
    output logic [CNT_W-1:0] left_nxt_o
);
    always_comb begin
        want_word_o = 1'b0;
        advance_o   = 1'b0;
        is_word_o   = 1'b0;
        lead_nxt_o  = lead_i;
        left_nxt_o  = left_i;
        if (lead_i != 2'd0) begin
            advance_o  = 1'b1;
            lead_nxt_o = lead_i - 2'd1;
        end else if (left_i != '0) begin
            want_word_o = 1'b1;
            if (word_valid_i) begin
                advance_o  = 1'b1;
                is_word_o  = 1'b1;
                left_nxt_o = left_i - CNT_W'(1);
            end
        end else begin
            advance_o = 1'b1;
        end
    end
endmodule

// File: rtl/pkr_addr_step.sv
module pkr_addr_step #(
    parameter int ADDR_W = 16,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load_i) begin
            addr_o <= load_val_i;
        end else if (step_i) begin
            addr_o <= addr_o + ADDR_W'(STEP);
        end
    end
endmodule

// File: rtl/wr_burst_packer.sv
module wr_burst_packer
    import pkr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    output logic              word_ready_o,
    output logic              cmd_valid_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              beat_valid_o,
    output logic [BEAT_W-1:0] beat_data_o,
    output logic [MASK_W-1:0] beat_mask_o,
    input  logic              mc_ready_i
);
    pkr_state_e        state_q, state_d;
    logic [1:0]        lead_q;
    logic [CNT_W-1:0]  left_q;
    logic              lane_q;
    logic              beat_q;
    logic [BEAT_W-1:0] data_q;
    logic [MASK_W-1:0] mask_q;
    logic              done_q;

    logic              want_word, advance, is_word;
    logic [1:0]        lead_n;
    logic [CNT_W-1:0]  left_n;
    logic              accept_start, beat_acc, last_beat;
    logic [ADDR_W-1:0] addr_q;

    assign accept_start = start_i && (state_q == ST_IDLE);
    assign beat_acc     = (state_q == ST_SEND) && mc_ready_i;
    assign last_beat    = beat_q && (left_q == '0);

    pkr_lane_step #(.CNT_W(CNT_W)) u_lane (
        .lead_i      (lead_q),
        .left_i      (left_q),
        .word_valid_i(word_valid_i),
        .want_word_o (want_word),
        .advance_o   (advance),
        .is_word_o   (is_word),
        .lead_nxt_o  (lead_n),
        .left_nxt_o  (left_n)
    );

    pkr_addr_step #(.ADDR_W(ADDR_W), .STEP(BURST_WORDS)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept_start),
        .load_val_i(start_addr_i),
        .step_i    (beat_acc && beat_q),
        .addr_o    (addr_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept_start && (word_cnt_i != '0)) state_d = ST_FILL;
            ST_FILL: if (advance && lane_q) state_d = ST_SEND;
            ST_SEND: if (mc_ready_i) state_d = last_beat ? ST_IDLE : ST_FILL;
            default: state_d = ST_IDLE;
        endcase
    end

    // lane and beat datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= '0;
            left_q <= '0;
            lane_q <= 1'b0;
            beat_q <= 1'b0;
            data_q <= '0;
            mask_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (accept_start && (word_cnt_i == '0)) || (beat_acc && last_beat);
            if (accept_start) begin
                lead_q <= start_addr_i[1:0];
                left_q <= word_cnt_i;
                lane_q <= 1'b0;
                beat_q <= 1'b0;
            end
            if ((state_q == ST_FILL) && advance) begin
                lead_q <= lead_n;
                left_q <= left_n;
                lane_q <= ~lane_q;
                for (int l = 0; l < LANES; l++) begin
                    if (lane_q == 1'(l)) begin
                        data_q[l*WORD_W +: WORD_W]         <= is_word ? word_data_i : '0;
                        mask_q[l*LANE_BYTES +: LANE_BYTES] <= is_word ? '0 : '1;
                    end
                end
            end
            if (beat_acc) beat_q <= ~beat_q;
        end
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        word_ready_o = (state_q == ST_FILL) && want_word;
        beat_valid_o = (state_q == ST_SEND);
        cmd_valid_o  = (state_q == ST_SEND) && !beat_q;
        cmd_addr_o   = addr_q;
        beat_data_o  = data_q;
        beat_mask_o  = mask_q;
        done_o       = done_q;
    end
endmodule

// File: rtl/pkr_checker.sv
module pkr_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  word_cnt_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              word_ready_o,
    input logic              cmd_valid_o,
    input logic [ADDR_W-1:0] cmd_addr_o,
    input logic              beat_valid_o,
    input logic [63:0]       beat_data_o,
    input logic [7:0]        beat_mask_o,
    input logic              mc_ready_i
);
    logic second_half;

    always_ff @(posedge clk) begin
        if (!rst_n)                          second_half <= 1'b0;
        else if (beat_valid_o && mc_ready_i) second_half <= ~second_half;
    end

    p_cmd_with_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> beat_valid_o);

    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> (cmd_valid_o == !second_half));

    p_lane_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> ((beat_mask_o[3:0] == 4'h0) || (beat_mask_o[3:0] == 4'hF)) &&
                         ((beat_mask_o[7:4] == 4'h0) || (beat_mask_o[7:4] == 4'hF)));

    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> ((beat_mask_o[3:0] != 4'hF) || (beat_data_o[31:0] == 32'h0)) &&
                         ((beat_mask_o[7:4] != 4'hF) || (beat_data_o[63:32] == 32'h0)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !mc_ready_i |=> beat_valid_o && $stable(beat_data_o) &&
            $stable(beat_mask_o) && $stable(cmd_valid_o) && $stable(cmd_addr_o));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_zero_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (word_cnt_i == '0) |=> done_o && !beat_valid_o);

    p_ready_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready_o |-> busy_o && !beat_valid_o);
endmodule

bind wr_burst_packer pkr_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .word_cnt_i  (word_cnt_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .word_ready_o(word_ready_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_addr_o  (cmd_addr_o),
    .beat_valid_o(beat_valid_o),
    .beat_data_o (beat_data_o),
    .beat_mask_o (beat_mask_o),
    .mc_ready_i  (mc_ready_i)
);

// File: tb/sim_wr_burst_packer.sv
module sim_wr_burst_packer;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;
    localparam int NCASE  = 10;
    // {start address, word count, stall pattern}
    localparam logic [27:0] CASES [NCASE] = '{
        {16'd0,     8'd4,  4'h0},
        {16'd1,     8'd4,  4'h0},
        {16'd2,     8'd3,  4'h5},
        {16'd3,     8'd1,  4'h0},
        {16'd3,     8'd6,  4'h3},
        {16'd5,     8'd2,  4'h6},
        {16'd6,     8'd9,  4'h0},
        {16'd9,     8'd13, 4'h9},
        {16'd12,    8'd8,  4'hA},
        {16'hFFFD,  8'd5,  4'h1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic [CNT_W-1:0]  word_cnt_i = '0;
    logic              busy_o, done_o;
    logic              word_valid_i = 1'b0;
    logic [31:0]       word_data_i = '0;
    logic              word_ready_o;
    logic              cmd_valid_o;
    logic [ADDR_W-1:0] cmd_addr_o;
    logic              beat_valid_o;
    logic [63:0]       beat_data_o;
    logic [7:0]        beat_mask_o;
    logic              mc_ready_i = 1'b0;

    int errors = 0;
    int checks = 0;
    logic [31:0] mem [64];

    always #5 clk = ~clk;

    wr_burst_packer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .word_cnt_i(word_cnt_i), .busy_o(busy_o), .done_o(done_o),
        .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ready_o(word_ready_o),
        .cmd_valid_o(cmd_valid_o), .cmd_addr_o(cmd_addr_o), .beat_valid_o(beat_valid_o),
        .beat_data_o(beat_data_o), .beat_mask_o(beat_mask_o), .mc_ready_i(mc_ready_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int tc, input int idx);
        return 32'hC0DE_0000 | 32'(tc << 8) | 32'(idx);
    endfunction

    function automatic logic [31:0] bg_of(input int i);
        return 32'h5A5A_0000 | 32'(i);
    endfunction

    task automatic run_case(input int tc, input logic [15:0] sa, input logic [7:0] cnt,
                            input logic [3:0] stall, input bit inject);
        int widx = 0;
        int nbeat = 0;
        int last_acc = -10;
        int done_cyc = -1;
        int base = 0;
        int bad = 0;
        int bursts;
        bit stalled = 0;
        logic [63:0] pdata;
        logic [7:0]  pmask;
        logic        pcmd;
        logic [15:0] paddr;
        for (int i = 0; i < 64; i++) mem[i] = bg_of(i);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = sa; word_cnt_i = cnt;
        @(negedge clk);
        for (int cyc = 1; cyc < 3000; cyc++) begin
            start_i      = inject && (cyc == 4);
            start_addr_i = inject && (cyc == 4) ? 16'd40 : sa;
            word_cnt_i   = inject && (cyc == 4) ? 8'd3 : cnt;
            mc_ready_i   = !stall[cyc % 4];
            word_valid_i = (widx < int'(cnt)) && !stall[(cyc + 2) % 4];
            word_data_i  = word_of(tc, widx);
            #1;
            if (stalled) begin
                // R6: beat held while the controller stalls
                check(beat_valid_o && beat_data_o == pdata && beat_mask_o == pmask &&
                      cmd_valid_o == pcmd && (!pcmd || cmd_addr_o == paddr),
                      "R6", "stalled beat changed", beat_data_o, pdata);
            end
            if (word_valid_i && word_ready_o) widx++;
            if (beat_valid_o) begin
                // R2: strobe on first beat only
                check(cmd_valid_o == (nbeat % 2 == 0), "R2", "address strobe",
                      64'(cmd_valid_o), 64'(nbeat % 2 == 0));
                if (mc_ready_i) begin
                    if (nbeat % 2 == 0) begin
                        // R3: command address steps by 4 with wrap
                        check(cmd_addr_o == 16'(sa + 16'(4 * (nbeat / 2))), "R3", "command address",
                              64'(cmd_addr_o), 64'(16'(sa + 16'(4 * (nbeat / 2)))));
                        base = int'(cmd_addr_o & 16'hFFFC);
                    end
                    for (int l = 0; l < 2; l++) begin
                        logic [3:0] nib = beat_mask_o[l*4 +: 4];
                        // R5: lane nibble all or nothing, blocked lanes zero
                        check((nib == 4'h0) || (nib == 4'hF && beat_data_o[l*32 +: 32] == 32'h0),
                              "R5", "lane mask/data", {nib, beat_data_o[l*32 +: 32]}, 64'h0);
                        if (nib == 4'h0)
                            mem[(base + 2 * (nbeat % 2) + l) & 63] = beat_data_o[l*32 +: 32];
                    end
                    nbeat++;
                    last_acc = cyc;
                    stalled = 0;
                end else begin
                    stalled = 1;
                    pdata = beat_data_o; pmask = beat_mask_o;
                    pcmd = cmd_valid_o;  paddr = cmd_addr_o;
                end
            end else begin
                stalled = 0;
            end
            if (done_o) begin
                done_cyc = cyc;
                check(!busy_o, "R7", "busy low with done", 64'(busy_o), 64'd0);
                break;
            end
            @(negedge clk);
        end
        mc_ready_i = 1'b0; word_valid_i = 1'b0; start_i = 1'b0;
        bursts = (int'(sa[1:0]) + int'(cnt) + 3) / 4;
        check(done_cyc == last_acc + 1, "R7", "done timing", 64'(done_cyc), 64'(last_acc + 1));
        check(nbeat == 2 * bursts, "R2", "beat count", 64'(nbeat), 64'(2 * bursts));
        check(widx == int'(cnt), "R10", "words consumed", 64'(widx), 64'(cnt));
        for (int i = 0; i < 64; i++) begin
            int rel = (i - int'(sa[5:0])) & 63;
            logic [31:0] e = (rel < int'(cnt)) ? word_of(tc, rel) : bg_of(i);
            if (mem[i] !== e) begin
                if (bad == 0)
                    check(1'b0, "R4", $sformatf("image word %0d (case %0d, inject %0d -> R9)", i, tc, inject),
                          64'(mem[i]), 64'(e));
                bad++;
            end
        end
        if (bad == 0) check(1'b1, "R4", "image", 0, 0);
        @(negedge clk);
        check(!done_o, "R7", "done single cycle", 64'(done_o), 64'd0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: run did not end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy_o && !word_ready_o && !beat_valid_o && !cmd_valid_o && !done_o,
              "R1", "idle after reset",
              {59'd0, busy_o, word_ready_o, beat_valid_o, cmd_valid_o, done_o}, 64'd0);

        for (int t = 0; t < NCASE; t++)
            run_case(t, CASES[t][27:12], CASES[t][11:4], CASES[t][3:0], 1'b0);

        // R9: start pulse during a run is ignored
        run_case(20, 16'd7, 8'd10, 4'h2, 1'b1);

        // R8: zero count
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 16'd2; word_cnt_i = 8'd0; mc_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && !busy_o, "R8", "done after zero count",
              {62'd0, done_o, busy_o}, 64'd2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!beat_valid_o && !word_ready_o && !done_o, "R8", "no activity after zero count",
                  {61'd0, beat_valid_o, word_ready_o, done_o}, 64'd0);
        end
        mc_ready_i = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule